// File: doc/BRIEF.md
# Grouped Vector Reduction Tree

This block collapses a vector of sixteen 32-bit fixed-point lane operands into scalar results through a pipelined binary tree of combining stages. The lanes may be split into equal-sized groups, from pairs up to the whole vector. Each group is folded independently, so one operation yields between one and eight scalars. The fold is a wrapping signed sum, a signed maximum or a signed minimum.

Each scalar is tagged with the processing lane that should receive it. The block picks that lane itself from an internal destination pointer, and the instruction never names it. Results of one operation go to consecutive lanes starting at the pointer. After every accepted operation the pointer moves past the lanes just written. A loop such as a matrix multiply can therefore issue the same reduce instruction repeatedly and fill a result vector slot by slot. A clear command returns the pointer to lane 0 at the start of such a loop.

Top module: `vrn_reduce_top`

## Requirements
- R1: With op_i = 0 each result is the sum of its group's operands modulo 2^32 (two's complement wraparound).
- R2: With op_i = 1 each result is the largest operand of its group under signed comparison.
- R3: With op_i = 2 each result is the smallest operand of its group under signed comparison.
- R4: op_i = 3 gives exactly the same results as op_i = 0.
- R5: gsel_i = s selects a group size of G = 2^(s+1) lanes. The operation yields 16/G results, and result k (bits [32k+31:32k] of res_o) folds lanes kG to kG+G-1, with lane i taken from bits [32i+31:32i] of vec_i.
- R6: While out_valid_o is high, res_valid_o has bits 0 to 16/G-1 set and all other bits clear. While out_valid_o is low, res_valid_o is all zero.
- R7: An operation accepted on a rising edge (in_valid_i high) appears on the outputs right after the fourth rising edge counted from that one. A new operation may be accepted on every cycle, and results come out in issue order.
- R8: The destination lane of result k (bits [4k+3:4k] of res_lane_o) is (B + k) mod 16, where B is the pointer value used by that operation.
- R9: After each accepted operation the pointer becomes (B + 16/G) mod 16.
- R10: clr_i high on a rising edge sets the pointer to 0. If in_valid_i is also high on that edge, the operation uses B = 0. clr_i alone produces no output.
- R11: While reset is asserted and right after it, out_valid_o and res_valid_o are 0 and the pointer is 0.
- R12: Every result slot whose res_valid_o bit is clear shows zero on both res_o and res_lane_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Accept an operation this cycle |
| op_i | input | 2 | 0 add, 1 signed max, 2 signed min, 3 add |
| gsel_i | input | 2 | Group size select, G = 2^(gsel_i+1) |
| clr_i | input | 1 | Reset destination pointer to lane 0 |
| vec_i | input | 512 | Lane operands, lane i at bits [32i+31:32i] |
| out_valid_o | output | 1 | Results present this cycle |
| res_valid_o | output | 8 | Per-slot result valid |
| res_o | output | 256 | Results, slot k at bits [32k+31:32k] |
| res_lane_o | output | 32 | Destination lane per slot, slot k at bits [4k+3:4k] |

## Verification
The hardest situation to reach is several operations with different group sizes in flight at once while the pointer sits at a non-zero, unaligned position. In that state a stage that is idle for one operation must pass data through, the next stage must fold it, and lane numbers wrap past 15 inside a single result vector. The stimulus streams back-to-back operations whose group select and opcode change every cycle. It starts from pointer positions left behind by single-result reductions, and it fires a clear together with a valid operation in the middle of the stream.

// File: rtl/vrn_pkg.sv
package vrn_pkg;
  typedef enum logic [1:0] {
    OP_ADD  = 2'd0,
    OP_MAX  = 2'd1,
    OP_MIN  = 2'd2,
    OP_ADD2 = 2'd3
  } vrn_op_e;
endpackage

// File: rtl/vrn_alu.sv
module vrn_alu
  import vrn_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  vrn_op_e        op_i,
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  output logic [W-1:0]   y_o
);
  logic a_gt_b;
  assign a_gt_b = $signed(a_i) > $signed(b_i);

  always_comb begin
    unique case (op_i)
      OP_MAX:  y_o = a_gt_b ? a_i : b_i;
      OP_MIN:  y_o = a_gt_b ? b_i : a_i;
      default: y_o = a_i + b_i;
    endcase
  end
endmodule

// File: rtl/vrn_level.sv
module vrn_level
  import vrn_pkg::*;
#(
  parameter int unsigned W         = 32,
  parameter int unsigned LANES     = 16,
  parameter int unsigned LVL       = 1,
  parameter int unsigned SLOTS_IN  = 16,
  parameter int unsigned SLOTS_OUT = 8,
  parameter int unsigned GSW       = 2,
  parameter int unsigned LW        = 4
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            v_i,
  input  vrn_op_e                         op_i,
  input  logic [GSW-1:0]                  gsel_i,
  input  logic [LW-1:0]                   base_i,
  input  logic [SLOTS_IN-1:0][W-1:0]      data_i,
  output logic                            v_o,
  output vrn_op_e                         op_o,
  output logic [GSW-1:0]                  gsel_o,
  output logic [LW-1:0]                   base_o,
  output logic [SLOTS_OUT-1:0][W-1:0]     data_o
);
  localparam int unsigned PAIRS = LANES >> LVL;

  // level folds only if the group spans at least this level
  logic active;
  assign active = (int'(gsel_i) + 1) >= int'(LVL);

  logic [SLOTS_OUT-1:0][W-1:0] nxt;

  for (genvar k = 0; k < SLOTS_OUT; k++) begin : g_slot
    if (k < PAIRS) begin : g_pair
      logic [W-1:0] y;
      vrn_alu #(.W(W)) u_alu (
        .op_i (op_i),
        .a_i  (data_i[2*k]),
        .b_i  (data_i[2*k+1]),
        .y_o  (y)
      );
      assign nxt[k] = active ? y : data_i[k];
    end else begin : g_pass
      assign nxt[k] = active ? '0 : data_i[k];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_o    <= 1'b0;
      op_o   <= OP_ADD;
      gsel_o <= '0;
      base_o <= '0;
      data_o <= '0;
    end else begin
      v_o <= v_i;
      if (v_i) begin  // operand isolation on idle cycles
        op_o   <= op_i;
        gsel_o <= gsel_i;
        base_o <= base_i;
        data_o <= nxt;
      end
    end
  end
endmodule

// File: rtl/vrn_dest_ptr.sv
module vrn_dest_ptr #(
  parameter int unsigned LANES = 16,
  parameter int unsigned LW    = 4,
  parameter int unsigned GSW   = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            in_valid_i,
  input  logic            clr_i,
  input  logic [GSW-1:0]  gsel_i,
  output logic [LW-1:0]   base_o,
  output logic [LW-1:0]   ptr_o
);
  logic [LW-1:0] ptr_q;
  int unsigned   cnt_n;

  assign cnt_n  = LANES >> (32'(gsel_i) + 32'd1);
  assign base_o = clr_i ? '0 : ptr_q;
  assign ptr_o  = ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
    end else if (in_valid_i) begin
      ptr_q <= base_o + LW'(cnt_n);  // wraps mod LANES
    end else if (clr_i) begin
      ptr_q <= '0;
    end
  end
endmodule

// File: rtl/vrn_out_map.sv
module vrn_out_map #(
  parameter int unsigned W     = 32,
  parameter int unsigned LANES = 16,
  parameter int unsigned NRES  = 8,
  parameter int unsigned GSW   = 2,
  parameter int unsigned LW    = 4
) (
  input  logic                       v_i,
  input  logic [GSW-1:0]             gsel_i,
  input  logic [LW-1:0]              base_i,
  input  logic [NRES-1:0][W-1:0]     data_i,
  output logic                       out_valid_o,
  output logic [NRES-1:0]            res_valid_o,
  output logic [NRES*W-1:0]          res_o,
  output logic [NRES*LW-1:0]         res_lane_o
);
  int unsigned cnt_n;
  assign cnt_n       = LANES >> (32'(gsel_i) + 32'd1);
  assign out_valid_o = v_i;

  for (genvar k = 0; k < NRES; k++) begin : g_res
    logic sv;
    assign sv                     = v_i && (k < cnt_n);
    assign res_valid_o[k]         = sv;
    assign res_o[k*W +: W]        = sv ? data_i[k] : '0;
    assign res_lane_o[k*LW +: LW] = sv ? base_i + LW'(k) : '0;
  end
endmodule

// File: rtl/vrn_reduce_top.sv
module vrn_reduce_top
  import vrn_pkg::*;
#(
  parameter int unsigned LANES = 16,
  parameter int unsigned W     = 32,
  localparam int unsigned NLVL = $clog2(LANES),
  localparam int unsigned GSW  = (NLVL > 1) ? $clog2(NLVL) : 1,
  localparam int unsigned LW   = $clog2(LANES),
  localparam int unsigned NRES = LANES / 2
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   in_valid_i,
  input  logic [1:0]             op_i,
  input  logic [GSW-1:0]         gsel_i,
  input  logic                   clr_i,
  input  logic [LANES*W-1:0]     vec_i,
  output logic                   out_valid_o,
  output logic [NRES-1:0]        res_valid_o,
  output logic [NRES*W-1:0]      res_o,
  output logic [NRES*LW-1:0]     res_lane_o
);
  logic [LANES-1:0][W-1:0]   vec_a;
  logic [LW-1:0]             ptr_q;
  logic                      v_s    [0:NLVL];
  vrn_op_e                   op_s   [0:NLVL];
  logic [GSW-1:0]            gsel_s [0:NLVL];
  logic [LW-1:0]             base_s [0:NLVL];
  logic [NRES-1:0][W-1:0]    dat_s  [1:NLVL];

  assign vec_a     = vec_i;
  assign v_s[0]    = in_valid_i;
  assign op_s[0]   = vrn_op_e'(op_i);
  assign gsel_s[0] = gsel_i;

  vrn_dest_ptr #(.LANES(LANES), .LW(LW), .GSW(GSW)) u_ptr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .in_valid_i (in_valid_i),
    .clr_i      (clr_i),
    .gsel_i     (gsel_i),
    .base_o     (base_s[0]),
    .ptr_o      (ptr_q)
  );

  for (genvar l = 1; l <= NLVL; l++) begin : g_lvl
    if (l == 1) begin : g_first
      vrn_level #(
        .W(W), .LANES(LANES), .LVL(l), .SLOTS_IN(LANES),
        .SLOTS_OUT(NRES), .GSW(GSW), .LW(LW)
      ) u_level (
        .clk_i  (clk_i),        .rst_ni (rst_ni),
        .v_i    (v_s[l-1]),     .op_i   (op_s[l-1]),
        .gsel_i (gsel_s[l-1]),  .base_i (base_s[l-1]),
        .data_i (vec_a),
        .v_o    (v_s[l]),       .op_o   (op_s[l]),
        .gsel_o (gsel_s[l]),    .base_o (base_s[l]),
        .data_o (dat_s[l])
      );
    end else begin : g_next
      vrn_level #(
        .W(W), .LANES(LANES), .LVL(l), .SLOTS_IN(NRES),
        .SLOTS_OUT(NRES), .GSW(GSW), .LW(LW)
      ) u_level (
        .clk_i  (clk_i),        .rst_ni (rst_ni),
        .v_i    (v_s[l-1]),     .op_i   (op_s[l-1]),
        .gsel_i (gsel_s[l-1]),  .base_i (base_s[l-1]),
        .data_i (dat_s[l-1]),
        .v_o    (v_s[l]),       .op_o   (op_s[l]),
        .gsel_o (gsel_s[l]),    .base_o (base_s[l]),
        .data_o (dat_s[l])
      );
    end
  end

  vrn_out_map #(
    .W(W), .LANES(LANES), .NRES(NRES), .GSW(GSW), .LW(LW)
  ) u_out (
    .v_i         (v_s[NLVL]),
    .gsel_i      (gsel_s[NLVL]),
    .base_i      (base_s[NLVL]),
    .data_i      (dat_s[NLVL]),
    .out_valid_o (out_valid_o),
    .res_valid_o (res_valid_o),
    .res_o       (res_o),
    .res_lane_o  (res_lane_o)
  );
endmodule

// File: rtl/vrn_reduce_chk.sv
module vrn_reduce_chk #(
  parameter int unsigned LANES = 16,
  parameter int unsigned W     = 32,
  localparam int unsigned NLVL = $clog2(LANES),
  localparam int unsigned LW   = $clog2(LANES),
  localparam int unsigned NRES = LANES / 2
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                in_valid_i,
  input logic                clr_i,
  input logic                out_valid_o,
  input logic [NRES-1:0]     res_valid_o,
  input logic [NRES*W-1:0]   res_o,
  input logic [NRES*LW-1:0]  res_lane_o,
  input logic [LW-1:0]       ptr_q
);
  // issue history, one bit per tree level
  logic [NLVL-1:0] vsh;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vsh <= '0;
    else         vsh <= {vsh[NLVL-2:0], in_valid_i};
  end

  assert_latency_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o == vsh[NLVL-1]);

  assert_prefix_mask_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> res_valid_o[0] && ($countones({1'b0, res_valid_o} + 1'b1) == 1));

  assert_idle_mask_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_valid_o |-> res_valid_o == '0);

  assert_ptr_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !in_valid_i) |=> ptr_q == '0);

  for (genvar k = 0; k < NRES; k++) begin : g_k
    assert_unused_zero_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !res_valid_o[k] |-> (res_o[k*W +: W] == '0) && (res_lane_o[k*LW +: LW] == '0));
    if (k > 0) begin : g_seq
      assert_lane_consecutive_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        res_valid_o[k] |-> res_lane_o[k*LW +: LW] == LW'(res_lane_o[(k-1)*LW +: LW] + 1'b1));
    end
  end
endmodule

bind vrn_reduce_top vrn_reduce_chk #(.LANES(LANES), .W(W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .clr_i       (clr_i),
  .out_valid_o (out_valid_o),
  .res_valid_o (res_valid_o),
  .res_o       (res_o),
  .res_lane_o  (res_lane_o),
  .ptr_q       (ptr_q)
);

// File: tb/tb_vrn_reduce_top.sv
`timescale 1ns/1ps
module tb_vrn_reduce_top;
  localparam int L = 16;
  localparam int W = 32;
  localparam int NR = 8;
  localparam int LW = 4;

  typedef struct packed {
    logic [31:0]              t;
    logic [1:0]               op;
    logic [NR-1:0]            m;
    logic [NR-1:0][LW-1:0]    ln;
    logic [NR-1:0][W-1:0]     r;
  } exp_t;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic in_valid_i = 1'b0, clr_i = 1'b0;
  logic [1:0] op_i = '0, gsel_i = '0;
  logic [L-1:0][W-1:0] vec = '0;
  logic out_valid_o;
  logic [NR-1:0] res_valid_o;
  logic [NR*W-1:0] res_o;
  logic [NR*LW-1:0] res_lane_o;

  always #5 clk = ~clk;

  vrn_reduce_top dut (
    .clk_i(clk), .rst_ni(rst_ni), .in_valid_i(in_valid_i), .op_i(op_i),
    .gsel_i(gsel_i), .clr_i(clr_i), .vec_i(vec), .out_valid_o(out_valid_o),
    .res_valid_o(res_valid_o), .res_o(res_o), .res_lane_o(res_lane_o)
  );

  int n_chk = 0, n_fail = 0;
  int cyc = 0;
  int ptr_m = 0;
  bit done = 0;
  logic [31:0] seed = 32'h1234_5678;
  exp_t q[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic logic [31:0] fold(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b);
    case (op)
      2'd1:    return ($signed(a) > $signed(b)) ? a : b;
      2'd2:    return ($signed(a) < $signed(b)) ? a : b;
      default: return a + b;
    endcase
  endfunction

  function automatic logic [31:0] rnd();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return seed;
  endfunction

  task automatic send(input logic [1:0] op, input int gs, input logic [L-1:0][W-1:0] v, input bit clr);
    exp_t e;
    int g, n, base;
    logic [31:0] acc;
    g = 2 << gs;
    n = L / g;
    base = clr ? 0 : ptr_m;
    e = '0;
    for (int k = 0; k < NR; k++) begin
      if (k < n) begin
        acc = v[k*g];
        for (int j = 1; j < g; j++) acc = fold(op, acc, v[k*g+j]);
        e.r[k]  = acc;
        e.m[k]  = 1'b1;
        e.ln[k] = LW'((base + k) % L);
      end
    end
    ptr_m = (base + n) % L;
    @(negedge clk);
    in_valid_i = 1'b1; clr_i = clr; op_i = op; gsel_i = 2'(gs); vec = v;
    e.t = cyc; e.op = op;
    q.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid_i = 1'b0; clr_i = 1'b0;
    end
  endtask

  task automatic clear_only();
    @(negedge clk);
    in_valid_i = 1'b0; clr_i = 1'b1;
    ptr_m = 0;
  endtask

  function automatic logic [L-1:0][W-1:0] rvec();
    logic [L-1:0][W-1:0] v;
    for (int i = 0; i < L; i++) v[i] = rnd();
    return v;
  endfunction

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_ni && !done) begin
      if (out_valid_o) begin
        if (q.size() == 0) begin
          chk(1'b0, "R7 unexpected output", 32'(res_valid_o), 32'h0);
        end else begin
          exp_t e;
          string tag;
          e = q.pop_front();
          case (e.op)
            2'd1: tag = "R2/R5";
            2'd2: tag = "R3/R5";
            2'd3: tag = "R4/R5";
            default: tag = "R1/R5";
          endcase
          chk(cyc - int'(e.t) == 4, "R7 latency", 32'(cyc - int'(e.t)), 32'd4);
          chk(res_valid_o == e.m, "R6 mask", 32'(res_valid_o), 32'(e.m));
          for (int k = 0; k < NR; k++) begin
            if (e.m[k]) begin
              chk(res_o[k*W +: W] == e.r[k], tag, res_o[k*W +: W], e.r[k]);
              chk(res_lane_o[k*LW +: LW] == e.ln[k], "R8/R9/R10 lane",
                  32'(res_lane_o[k*LW +: LW]), 32'(e.ln[k]));
            end else begin
              chk(res_o[k*W +: W] == '0 && res_lane_o[k*LW +: LW] == '0, "R12 unused slot",
                  res_o[k*W +: W], 32'h0);
            end
          end
        end
      end else begin
        chk(res_valid_o == '0, "R6 idle mask", 32'(res_valid_o), 32'h0);
      end
    end
  end

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    chk(1'b0, "watchdog", 32'(cyc), 32'h0);
    finish_run();
  end

  initial begin
    logic [L-1:0][W-1:0] v;
    repeat (3) @(negedge clk);
    chk(out_valid_o == 1'b0 && res_valid_o == '0, "R11 in reset", 32'(out_valid_o), 32'h0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(out_valid_o == 1'b0 && res_valid_o == '0, "R11 after reset", 32'(res_valid_o), 32'h0);

    // R1 full add, pointer starts at 0 (R11)
    for (int i = 0; i < L; i++) v[i] = 32'(i + 1);
    send(2'd0, 3, v, 0);
    // R1 wraparound
    for (int i = 0; i < L; i++) v[i] = 32'h7fff_ffff;
    send(2'd0, 3, v, 0);
    // R2/R3 negatives, each group size
    for (int i = 0; i < L; i++) v[i] = (i % 3 == 0) ? -32'(i + 5) : 32'(i * 7 - 40);
    for (int gs = 0; gs < 4; gs++) send(2'd1, gs, v, 0);
    for (int gs = 0; gs < 4; gs++) send(2'd2, gs, v, 0);
    // R4 alternate add encoding
    send(2'd3, 1, v, 0);
    idle(6);

    // R10 clear alone, then op from lane 0
    clear_only();
    idle(2);
    send(2'd0, 0, rvec(), 0);
    idle(1);
    // unaligned pointer then wrapping groups (R8, R9)
    for (int i = 0; i < 3; i++) send(2'd1, 3, rvec(), 0);
    send(2'd2, 0, rvec(), 0);
    send(2'd0, 1, rvec(), 0);
    idle(3);

    // mixed back-to-back stream with a mid-stream clear+valid (R7, R10)
    for (int i = 0; i < 40; i++) begin
      send(2'(i % 4), (i * 3 + i / 4) % 4, rvec(), i == 17);
    end
    idle(2);
    for (int i = 0; i < 12; i++) begin
      send(2'(rnd() % 4), int'(rnd() % 4), rvec(), 0);
      if (i % 3 == 0) idle(1);
    end
    idle(10);
    chk(q.size() == 0, "R7 drained", 32'(q.size()), 32'h0);
    finish_run();
  end
endmodule